// File: doc/BRIEF.md
# Seconds Counter with Alarm

This block keeps wall-clock time as a single wide count that advances once per pulse of a 32.768 kHz enable. The upper 32 bits of the count are whole seconds and the lower 15 bits are the sub-second fraction, so the seconds field steps exactly once every 32768 ticks. Software reaches the count through a small register bus. The bus has one word for the seconds and another for the fraction, plus a seconds alarm, a control word and a status word.

Counting stops in several cases. It stops when the run bit is clear. It stops when a wrap past the largest count has raised the overflow flag. It stops while the external non-valid input is high. It stops while the security monitor reports a failure, and in that case the frozen count records when the failure happened. A soft lock input and a hard lock input each block any rewrite of the time and of the run bit. The alarm compares the seconds field with a programmed value and sets a sticky flag. That flag can drive an interrupt line.

Top module: `rtc_core`

## Requirements
- R1: After reset the seconds word (address 0) and fraction word (address 1) read 0, the alarm word (address 2) reads 0xFFFFFFFF, control (address 3) and status (address 4) read 0, and `irq_o` is low.
- R2: The count rises by one on a clock edge with `tick_i` high only while control bit 0 (run) is 1, status bit 1 (overflow) is 0 and `nonvalid_i` is 0. Status bit 2 reads 1 exactly when these conditions for counting hold.
- R3: The count is 47 bits wide. A fraction step from 0x7FFF wraps the fraction to 0 and adds one to the seconds. The fraction word reads in bits 14:0 with the upper bits zero.
- R4: A write to address 1 loads bits 14:0 into the fraction. A write to address 0 loads all 32 bits into the seconds. A load wins over a tick in the same cycle, and later ticks continue from the loaded value.
- R5: The seconds and fraction are held in one register updated on a single edge, so a seconds read never shows a half-applied carry.
- R6: While `fail_i` is high the count is frozen even with run set, and it resumes when `fail_i` falls.
- R7: The alarm flag (status bit 0) is set on any edge where the seconds equal the alarm word. It stays set after the seconds move on, and setting wins over a same-cycle clear.
- R8: `irq_o` is high exactly when the alarm flag and control bit 1 (alarm interrupt enable) are both 1.
- R9: Writing status with bit 0 set clears the alarm flag. Writing a 0 in that position leaves the flag unchanged.
- R10: While `lock_soft_i` or `lock_hard_i` is high, writes to the seconds word, the fraction word and control bit 0 are ignored. Control bit 1 stays writable, and the count keeps running.
- R11: A tick at the largest count wraps the count to 0, sets the overflow flag (status bit 1) and halts counting. Writing status with bit 1 set clears the flag, and counting then resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | 32.768 kHz count enable, one clock wide per tick |
| nonvalid_i | input | 1 | Non-valid state from the security monitor; halts counting |
| fail_i | input | 1 | Security failure state; freezes the count |
| lock_soft_i | input | 1 | Soft lock on time and run-bit writes |
| lock_hard_i | input | 1 | Hard lock on time and run-bit writes |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Read data for the addressed register, combinational |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The assertions watch these rules on every cycle:
- the count stays frozen while non-valid, failure or overflow holds;
- the count steps only by one or to zero unless a load occurs;
- a seconds match always leaves the alarm flag set on the following edge;
- under lock with no tick, neither the count nor the run bit moves;
- the interrupt never rises without the flag.

Some behaviour only the bench scenarios can show. These are the exact values after a carry and after a wrap, a load taking priority over a simultaneous tick, a clear losing to a live match, and the flag staying set once the seconds move past the alarm. Only the scenarios also show that writes made under lock leave the register values unchanged.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
// rtc_pkg: register selectors, bit positions and the write-strobe bundle
// shared by the seconds counter, its alarm and its bus decoder.
package rtc_pkg;

    // Register selectors on the software bus.
    typedef enum logic [2:0] {
        REG_SECS  = 3'd0,
        REG_FRAC  = 3'd1,
        REG_ALARM = 3'd2,
        REG_CTRL  = 3'd3,
        REG_STAT  = 3'd4
    } reg_sel_e;

    // Control word bits.
    localparam int CTRL_RUN = 0;
    localparam int CTRL_AIE = 1;

    // Status word bits.
    localparam int STAT_ALM = 0;
    localparam int STAT_OVF = 1;
    localparam int STAT_ACT = 2;

    // Write strobes after lock gating.
    typedef struct packed {
        logic secs;
        logic frac;
        logic alarm;
        logic ctrl_run;
        logic ctrl_aie;
        logic stat;
    } wr_strobe_t;

endpackage

// File: rtl/rtc_bus_dec.sv
`timescale 1ns/1ps
// rtc_bus_dec: decodes the register bus into per-register write strobes,
// suppresses the time and run-bit strobes while a lock is active, and
// multiplexes the read word.
// Assumes: single-cycle writes, reads are combinational from the address,
// SEC_W <= DATA_W and FRAC_W < DATA_W.
module rtc_bus_dec
    import rtc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              locked_i,
    input  logic [SEC_W-1:0]  secs_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic [SEC_W-1:0]  alarm_i,
    input  logic              run_i,
    input  logic              aie_i,
    input  logic              alm_flag_i,
    input  logic              ovf_i,
    input  logic              active_i,
    output wr_strobe_t        strobe_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam logic [ADDR_W-1:0] A_SECS  = ADDR_W'(REG_SECS);
    localparam logic [ADDR_W-1:0] A_FRAC  = ADDR_W'(REG_FRAC);
    localparam logic [ADDR_W-1:0] A_ALARM = ADDR_W'(REG_ALARM);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(REG_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(REG_STAT);

    // Write decode with lock gating on time and run bit.
    always_comb begin
        strobe_o          = '0;
        strobe_o.secs     = we_i && (addr_i == A_SECS) && !locked_i;
        strobe_o.frac     = we_i && (addr_i == A_FRAC) && !locked_i;
        strobe_o.alarm    = we_i && (addr_i == A_ALARM);
        strobe_o.ctrl_run = we_i && (addr_i == A_CTRL) && !locked_i;
        strobe_o.ctrl_aie = we_i && (addr_i == A_CTRL);
        strobe_o.stat     = we_i && (addr_i == A_STAT);
    end

    // Read multiplexer.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_SECS:  rdata_o = DATA_W'(secs_i);
            A_FRAC:  rdata_o = DATA_W'(frac_i);
            A_ALARM: rdata_o = DATA_W'(alarm_i);
            A_CTRL: begin
                rdata_o[CTRL_RUN] = run_i;
                rdata_o[CTRL_AIE] = aie_i;
            end
            A_STAT: begin
                rdata_o[STAT_ALM] = alm_flag_i;
                rdata_o[STAT_OVF] = ovf_i;
                rdata_o[STAT_ACT] = active_i;
            end
            default: rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/rtc_counter.sv
`timescale 1ns/1ps
// rtc_counter: the combined seconds+fraction count, its run bit and its
// overflow flag. The whole count sits in one register, so seconds and
// fraction always change together on one edge.
// Assumes: tick_i is one clock wide per 32.768 kHz period; at most one of
// ld_secs_i / ld_frac_i is high in a cycle; FRAC_W <= SEC_W.
module rtc_counter #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              hold_i,
    input  logic              ld_secs_i,
    input  logic              ld_frac_i,
    input  logic [SEC_W-1:0]  ld_val_i,
    input  logic              run_wr_i,
    input  logic              run_val_i,
    input  logic              ovf_clr_i,
    output logic [SEC_W-1:0]  secs_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic              run_o,
    output logic              ovf_o,
    output logic              active_o
);

    localparam int CNT_W = SEC_W + FRAC_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;
    logic             step;
    logic             load;

    assign active_o = run_o && !ovf_o && !hold_i;
    assign load     = ld_secs_i || ld_frac_i;
    assign step     = tick_i && active_o && !load;
    assign cnt_inc  = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    assign secs_o   = cnt_q[CNT_W-1:FRAC_W];
    assign frac_o   = cnt_q[FRAC_W-1:0];

    // Count register: loads win over a tick, otherwise advance and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld_secs_i) begin
            cnt_q[CNT_W-1:FRAC_W] <= ld_val_i;
        end else if (ld_frac_i) begin
            cnt_q[FRAC_W-1:0] <= ld_val_i[FRAC_W-1:0];
        end else if (step) begin
            cnt_q <= cnt_inc[CNT_W-1:0];
        end
    end

    // Overflow flag: set by a wrapping step, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_o <= 1'b0;
        end else if (step && cnt_inc[CNT_W]) begin
            ovf_o <= 1'b1;
        end else if (ovf_clr_i) begin
            ovf_o <= 1'b0;
        end
    end

    // Run bit: software controlled, lock gating done upstream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_o <= 1'b0;
        end else if (run_wr_i) begin
            run_o <= run_val_i;
        end
    end

endmodule

// File: rtl/rtc_alarm.sv
`timescale 1ns/1ps
// rtc_alarm: seconds compare register, sticky alarm flag and interrupt
// enable. The flag is set on every edge where the seconds match, which
// takes priority over a software clear in the same cycle.
// Assumes: seconds input comes straight from the count register.
module rtc_alarm #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEC_W-1:0] secs_i,
    input  logic             wr_alarm_i,
    input  logic [SEC_W-1:0] wdata_i,
    input  logic             wr_aie_i,
    input  logic             aie_val_i,
    input  logic             flag_clr_i,
    output logic [SEC_W-1:0] alarm_o,
    output logic             flag_o,
    output logic             aie_o,
    output logic             irq_o
);

    logic match;

    assign match = (secs_i == alarm_o);
    assign irq_o = flag_o && aie_o;

    // Alarm compare value, parked at all ones out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_o <= '1;
        end else if (wr_alarm_i) begin
            alarm_o <= wdata_i;
        end
    end

    // Sticky alarm flag: match sets, write-one clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (match) begin
            flag_o <= 1'b1;
        end else if (flag_clr_i) begin
            flag_o <= 1'b0;
        end
    end

    // Alarm interrupt enable, writable regardless of locks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aie_o <= 1'b0;
        end else if (wr_aie_i) begin
            aie_o <= aie_val_i;
        end
    end

endmodule

// File: rtl/rtc_core.sv
`timescale 1ns/1ps
// rtc_core: seconds counter with alarm. Joins the bus decoder, the count
// and the alarm compare; the security monitor's non-valid and failure
// inputs hold the count, the lock inputs block time and run-bit writes.
// Assumes: all inputs are already synchronous to clk.
module rtc_core
    import rtc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              nonvalid_i,
    input  logic              fail_i,
    input  logic              lock_soft_i,
    input  logic              lock_hard_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);

    wr_strobe_t        strb;
    logic [SEC_W-1:0]  secs_w;
    logic [FRAC_W-1:0] frac_w;
    logic [SEC_W-1:0]  alarm_w;
    logic              run_w;
    logic              ovf_w;
    logic              active_w;
    logic              alm_flag_w;
    logic              aie_w;
    logic              locked;
    logic              hold;
    logic              cnt_load;

    assign locked   = lock_soft_i || lock_hard_i;
    assign hold     = nonvalid_i || fail_i;
    assign cnt_load = strb.secs || strb.frac;

    rtc_bus_dec #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .SEC_W  (SEC_W),
        .FRAC_W (FRAC_W)
    ) u_dec (
        .we_i       (bus_we_i),
        .addr_i     (bus_addr_i),
        .locked_i   (locked),
        .secs_i     (secs_w),
        .frac_i     (frac_w),
        .alarm_i    (alarm_w),
        .run_i      (run_w),
        .aie_i      (aie_w),
        .alm_flag_i (alm_flag_w),
        .ovf_i      (ovf_w),
        .active_i   (active_w),
        .strobe_o   (strb),
        .rdata_o    (bus_rdata_o)
    );

    rtc_counter #(
        .SEC_W  (SEC_W),
        .FRAC_W (FRAC_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .hold_i    (hold),
        .ld_secs_i (strb.secs),
        .ld_frac_i (strb.frac),
        .ld_val_i  (bus_wdata_i[SEC_W-1:0]),
        .run_wr_i  (strb.ctrl_run),
        .run_val_i (bus_wdata_i[CTRL_RUN]),
        .ovf_clr_i (strb.stat && bus_wdata_i[STAT_OVF]),
        .secs_o    (secs_w),
        .frac_o    (frac_w),
        .run_o     (run_w),
        .ovf_o     (ovf_w),
        .active_o  (active_w)
    );

    rtc_alarm #(
        .SEC_W (SEC_W)
    ) u_alm (
        .clk        (clk),
        .rst_n      (rst_n),
        .secs_i     (secs_w),
        .wr_alarm_i (strb.alarm),
        .wdata_i    (bus_wdata_i[SEC_W-1:0]),
        .wr_aie_i   (strb.ctrl_aie),
        .aie_val_i  (bus_wdata_i[CTRL_AIE]),
        .flag_clr_i (strb.stat && bus_wdata_i[STAT_ALM]),
        .alarm_o    (alarm_w),
        .flag_o     (alm_flag_w),
        .aie_o      (aie_w),
        .irq_o      (irq_o)
    );

endmodule

// File: rtl/rtc_core_chk.sv
`timescale 1ns/1ps
// rtc_core_chk: temporal checks on the seconds counter, bound to rtc_core.
// Assumes: synchronous active-low reset; count is {seconds, fraction}.
module rtc_core_chk #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    tick_i,
    input logic                    nonvalid_i,
    input logic                    fail_i,
    input logic                    lock_soft_i,
    input logic                    lock_hard_i,
    input logic                    cnt_load,
    input logic [SEC_W+FRAC_W-1:0] count,
    input logic [SEC_W-1:0]        secs,
    input logic [SEC_W-1:0]        alarm,
    input logic                    run,
    input logic                    ovf,
    input logic                    alm_flag,
    input logic                    irq_o
);

    localparam int CW = SEC_W + FRAC_W;

    // R2: non-valid input holds the count.
    a_r2_nonvalid_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (nonvalid_i && !cnt_load) |=> $stable(count));

    // R6: failure input freezes the count.
    a_r6_fail_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_i && !cnt_load) |=> $stable(count));

    // R3: without a load the count holds, steps by one or wraps to zero.
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_load |=> (count == $past(count) || count == $past(count) + CW'(1)
                       || count == '0));

    // R7: a seconds match leaves the alarm flag set on the next edge.
    a_r7_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (secs == alarm) |=> alm_flag);

    // R8: the interrupt is never raised without the alarm flag.
    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> alm_flag);

    // R10: under any lock and with no tick, count and run bit stay put.
    a_r10_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ((lock_soft_i || lock_hard_i) && !tick_i) |=> ($stable(count) && $stable(run)));

    // R11: with the overflow flag set, the count does not move unless loaded.
    a_r11_ovf_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !cnt_load) |=> $stable(count));

endmodule

bind rtc_core rtc_core_chk #(
    .SEC_W  (SEC_W),
    .FRAC_W (FRAC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .nonvalid_i  (nonvalid_i),
    .fail_i      (fail_i),
    .lock_soft_i (lock_soft_i),
    .lock_hard_i (lock_hard_i),
    .cnt_load    (cnt_load),
    .count       ({secs_w, frac_w}),
    .secs        (secs_w),
    .alarm       (alarm_w),
    .run         (run_w),
    .ovf         (ovf_w),
    .alm_flag    (alm_flag_w),
    .irq_o       (irq_o)
);

// File: tb/sim_rtc_core.sv
`timescale 1ns/1ps
// sim_rtc_core: scoreboard bench. Driver tasks queue expected read words;
// a monitor pops and compares them one nanosecond after each falling edge.
module sim_rtc_core;

    localparam logic [2:0] A_SECS = 3'd0, A_FRAC = 3'd1, A_ALARM = 3'd2,
                           A_CTRL = 3'd3, A_STAT = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        nonvalid_i = 1'b0;
    logic        fail_i = 1'b0;
    logic        lock_soft_i = 1'b0;
    logic        lock_hard_i = 1'b0;
    logic        bus_we_i = 1'b0;
    logic [2:0]  bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        irq_o;

    int          n_chk = 0;
    int          n_bad = 0;
    bit          probe = 1'b0;
    bit          done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    rtc_core u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .nonvalid_i  (nonvalid_i),
        .fail_i      (fail_i),
        .lock_soft_i (lock_soft_i),
        .lock_hard_i (lock_hard_i),
        .bus_we_i    (bus_we_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .irq_o       (irq_o)
    );

    // Monitor: compare the read word against the queued expectation.
    always @(negedge clk) begin
        #1;
        if (probe && exp_q.size() > 0) begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (bus_rdata_o !== e) begin
                n_bad++;
                $display("FAIL %s: read %h expected %h", t, bus_rdata_o, e);
            end
        end
    end

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_addr_i = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        probe = 1'b1;
        @(negedge clk);
        probe = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we_i    = 1'b1;
        bus_addr_i  = a;
        bus_wdata_i = d;
        @(negedge clk);
        bus_we_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk);
        #1;
        n_chk++;
        if (irq_o !== e) begin
            n_bad++;
            $display("FAIL %s: irq %b expected %b", t, irq_o, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    // Stimulus driver.
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd(A_SECS, 32'h0, "R1 secs");
        rd(A_FRAC, 32'h0, "R1 frac");
        rd(A_ALARM, 32'hFFFF_FFFF, "R1 alarm");
        rd(A_CTRL, 32'h0, "R1 ctrl");
        rd(A_STAT, 32'h0, "R1 stat");
        chk_irq(1'b0, "R1 irq");

        // R2: no counting with run clear, then counting with run set
        ticks(4);
        rd(A_FRAC, 32'h0, "R2 run clear");
        wr(A_CTRL, 32'h1);
        rd(A_STAT, 32'h4, "R2 active bit");
        ticks(5);
        rd(A_FRAC, 32'h5, "R2 five ticks");

        // R4 loads, R3 carry into seconds
        wr(A_FRAC, 32'h0000_7FFE);
        wr(A_SECS, 32'd10);
        rd(A_SECS, 32'd10, "R4 secs load");
        rd(A_FRAC, 32'h7FFE, "R4 frac load");
        ticks(3);
        rd(A_SECS, 32'd11, "R3 carry secs");
        rd(A_FRAC, 32'h1, "R3 carry frac");

        // R4: load beats a same-cycle tick
        @(negedge clk);
        bus_we_i = 1'b1; bus_addr_i = A_FRAC; bus_wdata_i = 32'hFFFF_0100; tick_i = 1'b1;
        @(negedge clk);
        bus_we_i = 1'b0; tick_i = 1'b0;
        rd(A_FRAC, 32'h100, "R4 load over tick");
        ticks(1);
        rd(A_FRAC, 32'h101, "R4 continue after load");

        // R2: non-valid halts
        nonvalid_i = 1'b1;
        ticks(6);
        rd(A_FRAC, 32'h101, "R2 nonvalid hold");
        rd(A_STAT, 32'h0, "R2 active clear");
        nonvalid_i = 1'b0;

        // R6: failure freezes, resumes after
        fail_i = 1'b1;
        ticks(6);
        rd(A_SECS, 32'd11, "R6 fail secs");
        rd(A_FRAC, 32'h101, "R6 fail frac");
        fail_i = 1'b0;
        ticks(1);
        rd(A_FRAC, 32'h102, "R6 resume");

        // R7/R8: alarm match, interrupt gated by enable
        wr(A_ALARM, 32'd12);
        wr(A_FRAC, 32'h7FFF);
        ticks(1);
        rd(A_SECS, 32'd12, "R7 secs at alarm");
        rd(A_STAT, 32'h5, "R7 flag set");
        chk_irq(1'b0, "R8 irq disabled");
        wr(A_CTRL, 32'h3);
        chk_irq(1'b1, "R8 irq enabled");
        wr(A_STAT, 32'h1);
        rd(A_STAT, 32'h5, "R7 set wins over clear");
        wr(A_STAT, 32'h0);
        rd(A_STAT, 32'h5, "R9 zero write no effect");
        wr(A_FRAC, 32'h7FFF);
        ticks(1);
        rd(A_SECS, 32'd13, "R7 moved past alarm");
        rd(A_STAT, 32'h5, "R7 sticky");
        wr(A_STAT, 32'h1);
        rd(A_STAT, 32'h4, "R9 flag cleared");
        chk_irq(1'b0, "R9 irq dropped");

        // R10: locks
        lock_soft_i = 1'b1;
        wr(A_SECS, 32'd99);
        rd(A_SECS, 32'd13, "R10 soft lock secs");
        wr(A_FRAC, 32'h5);
        rd(A_FRAC, 32'h0, "R10 soft lock frac");
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, 32'h1, "R10 run kept, aie written");
        ticks(2);
        rd(A_FRAC, 32'h2, "R10 runs under lock");
        lock_soft_i = 1'b0;
        lock_hard_i = 1'b1;
        wr(A_SECS, 32'd77);
        rd(A_SECS, 32'd13, "R10 hard lock secs");
        lock_hard_i = 1'b0;

        // R11: wrap sets overflow and halts until cleared
        wr(A_ALARM, 32'd5);
        wr(A_SECS, 32'hFFFF_FFFF);
        wr(A_FRAC, 32'h7FFF);
        ticks(1);
        rd(A_SECS, 32'h0, "R11 wrap secs");
        rd(A_FRAC, 32'h0, "R11 wrap frac");
        rd(A_STAT, 32'h2, "R11 ovf set");
        ticks(3);
        rd(A_FRAC, 32'h0, "R11 halted");
        wr(A_STAT, 32'h2);
        rd(A_STAT, 32'h4, "R11 ovf cleared");
        ticks(1);
        rd(A_FRAC, 32'h1, "R11 resumed");

        // R5: coherent seconds after a carry
        wr(A_FRAC, 32'h7FFF);
        ticks(1);
        rd(A_SECS, 32'd1, "R5 coherent secs");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule